// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a clocked host read and write an external asynchronous static RAM with a shared data bus. The host has a simple request/ready handshake. When `ready_o` is high at a clock edge and `req_i` is high, the block accepts one access. The access carries an address, write data and a write flag. A read returns its data with a one-cycle valid strobe.

On the memory side the block drives active-low select, write-strobe and output-enable pins and the address. The outbound data bus is split into a value and a driver-enable, so the pad tri-state sits outside this block. All memory pins come straight from flops, so they switch cleanly. Every timing figure of the memory is a parameter counted in clock periods, so a slower part or a different clock needs only new parameter values.

A sleep input parks the memory deselected for low-power data retention. When sleep is released, the host is held off until a recovery count has expired.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset, `ready_o` is 1. `mem_cs_n_o`, `mem_we_n_o` and `mem_oe_n_o` are all 1. `mem_dq_oe_o` and `rd_valid_o` are 0.
- R2: The memory pins only ever show one of these legal codes (select, write strobe, output enable, all active low):
  - idle: 1,1,1
  - output disabled: 0,1,1
  - read: 0,1,0
  - write: 0,0,1
- R3: A write keeps select and write strobe both low for exactly `WP_CYC` consecutive cycles. During that window the address and the driven data stay stable and `mem_dq_oe_o` is 1.
- R4: After a write window closes, the address and the data driver are held for `REC_CYC` cycles. `ready_o` rises `WP_CYC+REC_CYC` cycles after the accepting edge.
- R5: A read holds select and output enable low with a stable address for `RD_CYC` cycles. The memory data is captured on the edge that ends that interval. `rd_data_o` is presented with `rd_valid_o` high for exactly one cycle, right after that edge.
- R6: The controller never drives the data bus while output enable is low.
- R7: A write accepted in the cycle directly after a read completes gets one turnaround cycle. In that cycle the write strobe is high, output enable is high and the driver is off. A write that does not follow a read starts its window on the first cycle.
- R8: While `sleep_i` is high and the block is idle, select stays high and `ready_o` is low. Requests are ignored: memory contents are unchanged.
- R9: After `sleep_i` falls, `ready_o` stays low for exactly `WAKE_CYC` cycles before a new access can be accepted.
- R10: Data written to any address is returned unchanged by a later read of that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_i | input | 1 | Request low-power retention |
| req_i | input | 1 | Access request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Access address |
| req_wdata_i | input | DATA_W | Write data |
| ready_o | output | 1 | Block can accept a request this cycle |
| rd_valid_o | output | 1 | One-cycle read-data strobe |
| rd_data_o | output | DATA_W | Captured read data |
| mem_cs_n_o | output | 1 | Memory select, active low |
| mem_we_n_o | output | 1 | Memory write strobe, active low |
| mem_oe_n_o | output | 1 | Memory output enable, active low |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_dq_o | output | DATA_W | Data toward memory |
| mem_dq_oe_o | output | 1 | Enable for the data driver |
| mem_dq_i | input | DATA_W | Data from memory |

## Verification
All memory pins are registered, so they change one edge after the request is accepted. The read strobe is due `RD_CYC+1` falling edges after the accepting edge. Ready returns `WP_CYC+REC_CYC+1` falling edges after a write is accepted, and `WAKE_CYC` cycles after sleep is released. The bench samples only on falling edges and counts those edges from the accepting edge, so each result is compared at exactly the cycle it is due. The bench memory model returns inverted data until the address has been presented for `RD_CYC` cycles, so an early capture shows up as a data mismatch.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TURN,
        ST_READ,
        ST_WRITE,
        ST_WREC,
        ST_SLEEP,
        ST_WAKE
    } ctrl_state_e;

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             done_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = load_val_i;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done_o = (cnt_q == '0);

    AST_TIMER_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!load_i) && $past(cnt_q) != '0) |-> cnt_q == $past(cnt_q) - 1'b1); // R3

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter int DATA_W   = 4,
    parameter int RD_CYC   = 2,
    parameter int WP_CYC   = 1,
    parameter int REC_CYC  = 1,
    parameter int WAKE_CYC = 625000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_i,
    input  logic              req_i,
    input  logic              req_we_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    output logic              ready_o,
    output logic              rd_valid_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              mem_cs_n_o,
    output logic              mem_we_n_o,
    output logic              mem_oe_n_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe_o,
    input  logic [DATA_W-1:0] mem_dq_i
);

    localparam int MAX_A   = (RD_CYC > WP_CYC) ? RD_CYC : WP_CYC;
    localparam int MAX_B   = (REC_CYC > WAKE_CYC) ? REC_CYC : WAKE_CYC;
    localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    typedef struct packed {
        ctrl_state_e       state;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
        logic              rd_recent;
        logic              cs_n;
        logic              we_n;
        logic              oe_n;
        logic              dq_oe;
    } ctrl_regs_t;

    ctrl_regs_t       r_d, r_q;
    logic             t_load;
    logic [CNT_W-1:0] t_val;
    logic             t_done;

    sram_cycle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (t_load),
        .load_val_i (t_val),
        .done_o     (t_done)
    );

    always_comb begin
        r_d        = r_q;
        r_d.rvalid = 1'b0;
        t_load     = 1'b0;
        t_val      = '0;
        unique case (r_q.state)
            ST_IDLE: begin
                r_d.rd_recent = 1'b0;
                if (sleep_i) begin
                    r_d.state = ST_SLEEP;
                end else if (req_i) begin
                    r_d.addr  = req_addr_i;
                    r_d.wdata = req_wdata_i;
                    if (!req_we_i) begin
                        r_d.state = ST_READ;
                        t_load    = 1'b1;
                        t_val     = CNT_W'(RD_CYC - 1);
                    end else if (r_q.rd_recent) begin
                        r_d.state = ST_TURN;
                    end else begin
                        r_d.state = ST_WRITE;
                        t_load    = 1'b1;
                        t_val     = CNT_W'(WP_CYC - 1);
                    end
                end
            end
            ST_TURN: begin
                r_d.state = ST_WRITE;
                t_load    = 1'b1;
                t_val     = CNT_W'(WP_CYC - 1);
            end
            ST_READ: begin
                if (t_done) begin
                    r_d.rdata     = mem_dq_i;
                    r_d.rvalid    = 1'b1;
                    r_d.rd_recent = 1'b1;
                    r_d.state     = ST_IDLE;
                end
            end
            ST_WRITE: begin
                if (t_done) begin
                    r_d.state = ST_WREC;
                    t_load    = 1'b1;
                    t_val     = CNT_W'(REC_CYC - 1);
                end
            end
            ST_WREC: begin
                if (t_done) r_d.state = ST_IDLE;
            end
            ST_SLEEP: begin
                if (!sleep_i) begin
                    r_d.state = ST_WAKE;
                    t_load    = 1'b1;
                    t_val     = CNT_W'(WAKE_CYC - 1);
                end
            end
            ST_WAKE: begin
                if (t_done) r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase

        // Pin levels follow the next state so they leave flops directly.
        r_d.cs_n  = !(r_d.state inside {ST_TURN, ST_READ, ST_WRITE});
        r_d.we_n  = (r_d.state != ST_WRITE);
        r_d.oe_n  = (r_d.state != ST_READ);
        r_d.dq_oe = (r_d.state inside {ST_WRITE, ST_WREC});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
            r_q.cs_n  <= 1'b1;
            r_q.we_n  <= 1'b1;
            r_q.oe_n  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign ready_o     = (r_q.state == ST_IDLE) && !sleep_i;
    assign rd_valid_o  = r_q.rvalid;
    assign rd_data_o   = r_q.rdata;
    assign mem_cs_n_o  = r_q.cs_n;
    assign mem_we_n_o  = r_q.we_n;
    assign mem_oe_n_o  = r_q.oe_n;
    assign mem_addr_o  = r_q.addr;
    assign mem_dq_o    = r_q.wdata;
    assign mem_dq_oe_o = r_q.dq_oe;

    AST_WRITE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n_o |-> (!mem_cs_n_o && mem_oe_n_o)); // R2
    AST_READ_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n_o |-> (!mem_cs_n_o && mem_we_n_o)); // R2
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n_o && $past(!mem_cs_n_o)) |-> $stable(mem_addr_o)); // R3
    AST_WDATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dq_oe_o && $past(mem_dq_oe_o)) |-> ($stable(mem_dq_o) && $stable(mem_addr_o))); // R4
    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe_o |-> mem_oe_n_o); // R6
    AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |=> !rd_valid_o); // R5
    AST_TURN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!mem_oe_n_o) |-> !mem_dq_oe_o); // R7
    AST_SLEEP_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i && $past(sleep_i) && $past(ready_o == 1'b0) && mem_cs_n_o |=> mem_cs_n_o || !sleep_i || $past(r_q.state) != ST_SLEEP); // R8

endmodule

// File: tb/sram_async_ctrl_test.sv
module sram_async_ctrl_test;

    localparam int ADDR_W   = 6;
    localparam int DATA_W   = 4;
    localparam int RD_CYC   = 2;
    localparam int WP_CYC   = 2;
    localparam int REC_CYC  = 1;
    localparam int WAKE_CYC = 20;
    localparam int DEPTH    = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sleep_i = 1'b0;
    logic              req_i = 1'b0;
    logic              req_we_i = 1'b0;
    logic [ADDR_W-1:0] req_addr_i = '0;
    logic [DATA_W-1:0] req_wdata_i = '0;
    logic              ready_o, rd_valid_o;
    logic [DATA_W-1:0] rd_data_o;
    logic              mem_cs_n_o, mem_we_n_o, mem_oe_n_o, mem_dq_oe_o;
    logic [ADDR_W-1:0] mem_addr_o;
    logic [DATA_W-1:0] mem_dq_o, mem_dq_i;

    int checks = 0;
    int errors = 0;

    logic [DATA_W-1:0] mem [DEPTH];
    int                age = 0;
    logic [ADDR_W-1:0] age_addr = '0;
    int                win = 0;
    logic              win_prev = 1'b0;

    always #4 clk = ~clk;

    sram_async_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RD_CYC(RD_CYC),
        .WP_CYC(WP_CYC), .REC_CYC(REC_CYC), .WAKE_CYC(WAKE_CYC)
    ) uut (
        .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .req_i(req_i),
        .req_we_i(req_we_i), .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
        .ready_o(ready_o), .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
        .mem_cs_n_o(mem_cs_n_o), .mem_we_n_o(mem_we_n_o), .mem_oe_n_o(mem_oe_n_o),
        .mem_addr_o(mem_addr_o), .mem_dq_o(mem_dq_o), .mem_dq_oe_o(mem_dq_oe_o),
        .mem_dq_i(mem_dq_i)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Memory model: data only becomes valid after RD_CYC cycles of a steady read.
    assign mem_dq_i = (!mem_cs_n_o && mem_we_n_o && !mem_oe_n_o)
                    ? ((age >= RD_CYC) ? mem[mem_addr_o] : ~mem[mem_addr_o]) : '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_cs_n_o && mem_we_n_o && !mem_oe_n_o) begin
                age      <= (age > 0 && age_addr == mem_addr_o) ? age + 1 : 1;
                age_addr <= mem_addr_o;
            end else begin
                age <= 0;
            end
            if (!mem_cs_n_o && !mem_we_n_o && mem_dq_oe_o)
                mem[mem_addr_o] <= mem_dq_o;
            // R2: only legal pin codes
            if (mem_cs_n_o && (!mem_we_n_o || !mem_oe_n_o))
                chk(0, "R2 deselected code", {mem_we_n_o, mem_oe_n_o}, 3);
            if (!mem_we_n_o && (!mem_oe_n_o || !mem_dq_oe_o))
                chk(0, "R3 write window drive", {mem_oe_n_o, mem_dq_oe_o}, 3);
            // R6: no drive while memory may drive
            if (mem_dq_oe_o && !mem_oe_n_o)
                chk(0, "R6 contention", 1, 0);
            // R3: write window length
            if (!mem_we_n_o && !mem_cs_n_o) win <= win + 1;
            else win <= 0;
            win_prev <= !mem_we_n_o && !mem_cs_n_o;
            if (win_prev && mem_we_n_o) begin
                chk(win == WP_CYC, "R3 window length", win, WP_CYC);
                chk(mem_dq_oe_o == 1'b1, "R4 driver held after window", mem_dq_oe_o, 1);
            end
        end
    end

    task automatic issue(input bit we, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        while (!ready_o) @(negedge clk);
        req_i = 1'b1; req_we_i = we; req_addr_i = a; req_wdata_i = d;
        @(posedge clk);
        @(negedge clk);
        req_i = 1'b0;
    endtask

    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, input bit after_rd);
        int n;
        issue(1'b1, a, d);
        n = 1;
        if (after_rd) begin
            chk(mem_dq_oe_o == 0 && mem_we_n_o && mem_oe_n_o, "R7 turnaround cycle", mem_dq_oe_o, 0);
            @(negedge clk); n++;
        end
        chk(mem_dq_oe_o == 1 && !mem_we_n_o, "R7 window starts", mem_dq_oe_o, 1);
        while (!ready_o && n < 50) begin @(negedge clk); n++; end
        chk(n == WP_CYC + REC_CYC + 1 + (after_rd ? 1 : 0), "R4 ready return", n,
            WP_CYC + REC_CYC + 1 + (after_rd ? 1 : 0));
    endtask

    task automatic do_read(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] exp);
        int n;
        issue(1'b0, a, '0);
        n = 1;
        chk(ready_o == 0, "R7 busy during read", ready_o, 0);
        while (!rd_valid_o && n < 50) begin @(negedge clk); n++; end
        chk(n == RD_CYC + 1, "R5 read latency", n, RD_CYC + 1);
        chk(rd_data_o == exp, "R10 read data", rd_data_o, exp);
    endtask

    initial begin
        #200000;
        chk(0, "watchdog", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        for (int i = 0; i < DEPTH; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        chk(ready_o && mem_cs_n_o && mem_we_n_o && mem_oe_n_o && !mem_dq_oe_o && !rd_valid_o,
            "R1 reset state", {ready_o, mem_cs_n_o, mem_we_n_o, mem_oe_n_o}, 15);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 exhaustive write then read
        for (int a = 0; a < DEPTH; a++) do_write(a[ADDR_W-1:0], DATA_W'(a * 5 + 3), 1'b0);
        for (int a = 0; a < DEPTH; a++) begin
            do_read(a[ADDR_W-1:0], DATA_W'(a * 5 + 3));
            @(negedge clk);
        end

        // R7 read followed at once by write, then read back
        for (int a = 0; a < 8; a++) begin
            do_read(a[ADDR_W-1:0], DATA_W'(a * 5 + 3));
            do_write(a[ADDR_W-1:0], DATA_W'(a ^ 9), 1'b1);
            do_read(a[ADDR_W-1:0], DATA_W'(a ^ 9));
            @(negedge clk);
        end

        // R8 sleep ignores requests, R9 wake wait
        sleep_i = 1'b1;
        req_i = 1'b1; req_we_i = 1'b1; req_addr_i = 6'd40; req_wdata_i = 4'hF;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            chk(mem_cs_n_o && !ready_o, "R8 parked", {mem_cs_n_o, ready_o}, 2);
        end
        sleep_i = 1'b0;
        req_i = 1'b0;
        n = 0;
        while (!ready_o && n < 100) begin @(negedge clk); if (!ready_o) n++; end
        chk(n == WAKE_CYC, "R9 wake wait", n, WAKE_CYC);
        do_read(6'd40, DATA_W'(40 * 5 + 3));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule